// File: doc/BRIEF.md
# Word-Oriented LFSR with GF(2^8) Alpha Feedback

This block is the linear half of a word-based stream generator. It holds sixteen 32-bit stages. Each step shifts every stage down by one position and writes a new word into the top stage. The new word is not a tap XOR. It combines byte-shifted copies of two stages with two byte-to-word maps over GF(2^8): one multiplies by alpha and the other divides by alpha. Each map is applied to a single byte of its stage.

The nonlinear part of the generator reads three stages (0, 5 and 15) and returns a 32-bit word. In initialization mode that word is XORed into the feedback. In keystream mode it is left out. A wide parallel load writes all sixteen stages in one cycle. Every field power used by the alpha maps is reduced at elaboration to a constant 8x8 bit matrix, so the feedback path is one level of XOR trees with no iteration.

Top module: `alpha_lfsr`

## Requirements
- R1: While rst_n is low, and after its release until the first load or step, all stages read as zero on s0_word, s5_word and s15_word.
- R2: When load_en is high, stage i takes load_words[32*i+31:32*i] at the clock edge for every i in 0..15. This holds whether or not step_en is also high.
- R3: When step_en is high and load_en is low, stage i takes the old value of stage i+1 for i in 0..14.
- R4: In keystream mode (init_mode low), the new stage 15 is (S0 << 8) ^ up(S0[31:24]) ^ S2 ^ (S11 >> 8) ^ down(S11[7:0]). Both shifts are logical and fill with zeros, and the result is 32 bits wide.
- R5: In initialization mode (init_mode high), the new stage 15 is the R4 value XORed with nl_word.
- R6: up(c) puts x^23·c in bits 31:24, x^245·c in bits 23:16, x^48·c in bits 15:8 and x^239·c in bits 7:0.
- R7: down(c) puts x^16·c in bits 31:24, x^39·c in bits 23:16, x^6·c in bits 15:8 and x^64·c in bits 7:0.
- R8: Multiplying a byte by x shifts it left by one and XORs 0xA9 when the old bit 7 was set. x^0·c equals c.
- R9: When load_en and step_en are both low, no stage changes, whatever init_mode and nl_word are.
- R10: s0_word, s5_word and s15_word show the current contents of stages 0, 5 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Parallel load of all stages; has priority over step_en |
| load_words | input | 512 | Stage i is taken from bits 32*i+31:32*i |
| step_en | input | 1 | Advance the register by one word |
| init_mode | input | 1 | High: XOR nl_word into the feedback |
| nl_word | input | 32 | Word from the nonlinear part |
| s0_word | output | 32 | Stage 0 |
| s5_word | output | 32 | Stage 5 |
| s15_word | output | 32 | Stage 15 |

## Verification
Random register contents almost never drive a single active byte through the field maps. A wrong column in one power matrix, or a swapped output byte, can therefore hide behind the other terms. The stimulus loads registers in which only S0[31:24] or only S11[7:0] is nonzero. It uses the values 0x01, 0x80 and 0xFF, so that each map shows up alone in stage 15 and the 0xA9 reduction is forced. It then runs long random sequences that mix loads, holds and steps in both modes against a model that evaluates the powers by repeated multiplication.

// File: rtl/alpha_lfsr_pkg.sv
package alpha_lfsr_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FIELD_POLY = 8'hA9;

  // Powers of x applied by the two maps, most significant output byte first
  localparam int UP_P3 = 23;
  localparam int UP_P2 = 245;
  localparam int UP_P1 = 48;
  localparam int UP_P0 = 239;
  localparam int DN_P3 = 16;
  localparam int DN_P2 = 39;
  localparam int DN_P1 = 6;
  localparam int DN_P0 = 64;

  // One multiply-by-x step in GF(2^8) with the reduction constant
  function automatic logic [BYTE_W-1:0] gf_times_x(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    r = {b[BYTE_W-2:0], 1'b0};
    if (b[BYTE_W-1]) r = r ^ FIELD_POLY;
    return r;
  endfunction

  // x^n * b by repeated stepping; used only when elaborating constants
  function automatic logic [BYTE_W-1:0] gf_times_xn(input logic [BYTE_W-1:0] b,
                                                    input int n);
    logic [BYTE_W-1:0] r;
    r = b;
    for (int k = 0; k < n; k++) r = gf_times_x(r);
    return r;
  endfunction

  // Column j (bits 8j+7:8j) holds x^n applied to the basis byte 1<<j
  function automatic logic [BYTE_W*BYTE_W-1:0] gf_power_matrix(input int n);
    logic [BYTE_W*BYTE_W-1:0] m;
    m = '0;
    for (int j = 0; j < BYTE_W; j++)
      m[j*BYTE_W +: BYTE_W] = gf_times_xn(BYTE_W'(1) << j, n);
    return m;
  endfunction

endpackage

// File: rtl/gf_pow_matrix.sv
module gf_pow_matrix
  import alpha_lfsr_pkg::*;
#(
  parameter int POWER = 1
) (
  input  logic [BYTE_W-1:0] byte_in,
  output logic [BYTE_W-1:0] byte_out
);
  localparam logic [BYTE_W*BYTE_W-1:0] MAT = gf_power_matrix(POWER);

  // Linear map: XOR together the columns picked out by the set input bits
  always_comb begin
    byte_out = '0;
    for (int j = 0; j < BYTE_W; j++)
      if (byte_in[j]) byte_out = byte_out ^ MAT[j*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/alpha_word_map.sv
module alpha_word_map
  import alpha_lfsr_pkg::*;
#(
  parameter int P3 = 1,
  parameter int P2 = 1,
  parameter int P1 = 1,
  parameter int P0 = 1,
  parameter int WORD_W = 32
) (
  input  logic [BYTE_W-1:0] seed,
  output logic [WORD_W-1:0] word_out
);
  localparam int LANES = WORD_W / BYTE_W;
  localparam int POWS [4] = '{P0, P1, P2, P3};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    gf_pow_matrix #(.POWER(POWS[g])) u_pow (
      .byte_in (seed),
      .byte_out(word_out[g*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/alpha_feedback.sv
module alpha_feedback
  import alpha_lfsr_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] head_word,
  input  logic [WORD_W-1:0] near_word,
  input  logic [WORD_W-1:0] far_word,
  input  logic              inject,
  input  logic [WORD_W-1:0] inject_word,
  output logic [WORD_W-1:0] fb_word
);
  logic [WORD_W-1:0] up_term;
  logic [WORD_W-1:0] down_term;
  logic [WORD_W-1:0] linear_part;

  alpha_word_map #(.P3(UP_P3), .P2(UP_P2), .P1(UP_P1), .P0(UP_P0), .WORD_W(WORD_W)) u_up (
    .seed    (head_word[WORD_W-1 -: BYTE_W]),
    .word_out(up_term)
  );

  alpha_word_map #(.P3(DN_P3), .P2(DN_P2), .P1(DN_P1), .P0(DN_P0), .WORD_W(WORD_W)) u_down (
    .seed    (far_word[BYTE_W-1:0]),
    .word_out(down_term)
  );

  always_comb begin
    linear_part = (head_word << BYTE_W) ^ up_term ^ near_word
                ^ (far_word >> BYTE_W) ^ down_term;
    fb_word = inject ? (linear_part ^ inject_word) : linear_part;
  end
endmodule

// File: rtl/alpha_lfsr.sv
module alpha_lfsr
  import alpha_lfsr_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int STAGES   = 16,
  parameter int NEAR_TAP = 2,
  parameter int FAR_TAP  = 11,
  parameter int MID_OUT  = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_en,
  input  logic [STAGES*WORD_W-1:0]   load_words,
  input  logic                       step_en,
  input  logic                       init_mode,
  input  logic [WORD_W-1:0]          nl_word,
  output logic [WORD_W-1:0]          s0_word,
  output logic [WORD_W-1:0]          s5_word,
  output logic [WORD_W-1:0]          s15_word
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0][WORD_W-1:0] stage_q;
  logic [WORD_W-1:0]             fb_word;
  logic                          do_load;
  logic                          do_step;

  assign do_load = load_en;
  assign do_step = step_en && !load_en;

  alpha_feedback #(.WORD_W(WORD_W)) u_fb (
    .head_word  (stage_q[0]),
    .near_word  (stage_q[NEAR_TAP]),
    .far_word   (stage_q[FAR_TAP]),
    .inject     (init_mode),
    .inject_word(nl_word),
    .fb_word    (fb_word)
  );

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)       stage_q[i] <= '0;
      else if (do_load) stage_q[i] <= load_words[i*WORD_W +: WORD_W];
      else if (do_step) begin
        if (i == TOP) stage_q[i] <= fb_word;
        else          stage_q[i] <= stage_q[(i == TOP) ? i : i + 1];
      end
    end
  end

  assign s0_word  = stage_q[0];
  assign s5_word  = stage_q[MID_OUT];
  assign s15_word = stage_q[TOP];

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (s0_word == $past(load_words[WORD_W-1:0])));
  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en) |=> (s5_word == $past(stage_q[MID_OUT+1])));
  p_feedback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en) |=> (s15_word == $past(fb_word)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !load_en) |=> $stable(stage_q));
endmodule

// File: tb/sim_alpha_lfsr.sv
module sim_alpha_lfsr;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_en = 1'b0;
  logic [511:0]  load_words = '0;
  logic          step_en = 1'b0;
  logic          init_mode = 1'b0;
  logic [31:0]   nl_word = '0;
  logic [31:0]   s0_word, s5_word, s15_word;

  int checks = 0;
  int errors = 0;
  logic [31:0] ref_q [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  alpha_lfsr u0 (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_words(load_words),
    .step_en(step_en), .init_mode(init_mode), .nl_word(nl_word),
    .s0_word(s0_word), .s5_word(s5_word), .s15_word(s15_word)
  );

  // Reference field arithmetic, evaluated step by step
  function automatic logic [7:0] m_x(input logic [7:0] b);
    return b[7] ? ((b << 1) ^ 8'hA9) : (b << 1);
  endfunction
  function automatic logic [7:0] m_xn(input logic [7:0] b, input int n);
    logic [7:0] r = b;
    for (int k = 0; k < n; k++) r = m_x(r);
    return r;
  endfunction
  function automatic logic [31:0] m_up(input logic [7:0] c);
    return {m_xn(c, 23), m_xn(c, 245), m_xn(c, 48), m_xn(c, 239)};
  endfunction
  function automatic logic [31:0] m_down(input logic [7:0] c);
    return {m_xn(c, 16), m_xn(c, 39), m_xn(c, 6), m_xn(c, 64)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " s0"},  s0_word,  ref_q[0]);
    check({tag, " s5"},  s5_word,  ref_q[5]);
    check({tag, " s15"}, s15_word, ref_q[15]);
  endtask

  // One clock: drive at negedge, update model at the edge, compare at next negedge
  task automatic cycle(input logic ld, input logic [511:0] words, input logic st,
                       input logic im, input logic [31:0] nw, input string tag);
    logic [31:0] fb;
    load_en = ld; load_words = words; step_en = st; init_mode = im; nl_word = nw;
    @(posedge clk);
    if (ld) begin
      for (int i = 0; i < 16; i++) ref_q[i] = words[32*i +: 32];
    end else if (st) begin
      fb = (ref_q[0] << 8) ^ m_up(ref_q[0][31:24]) ^ ref_q[2]
         ^ (ref_q[11] >> 8) ^ m_down(ref_q[11][7:0]);
      if (im) fb = fb ^ nw;
      for (int i = 0; i < 15; i++) ref_q[i] = ref_q[i+1];
      ref_q[15] = fb;
    end
    @(negedge clk);
    check_all(tag);
  endtask

  function automatic logic [511:0] rand_words();
    logic [511:0] w;
    for (int i = 0; i < 16; i++) w[32*i +: 32] = $urandom;
    return w;
  endfunction

  // Only S0 top byte or S11 low byte set, everything else zero
  task automatic single_byte(input logic [7:0] v, input bit far);
    logic [511:0] w = '0;
    if (far) w[32*11 +: 8] = v; else w[31:24] = v;
    cycle(1'b1, w, 1'b0, 1'b0, 32'h0, "R2 load");
    for (int k = 0; k < 4; k++) cycle(1'b0, '0, 1'b1, 1'b0, 32'h0, far ? "R7 down" : "R6 up");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) ref_q[i] = '0;
    load_en = 1'b1; step_en = 1'b1; load_words = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    cycle(1'b0, '0, 1'b0, 1'b1, 32'hFFFF_FFFF, "R1 after reset");
    // R8: 0x80 forces the reduction; 0x01 exercises x^0 basis
    single_byte(8'h01, 1'b0);
    single_byte(8'h80, 1'b0);
    single_byte(8'hFF, 1'b0);
    single_byte(8'h01, 1'b1);
    single_byte(8'h80, 1'b1);
    single_byte(8'hFF, 1'b1);
    // R10 / R3: shifting a loaded pattern through the outputs
    cycle(1'b1, rand_words(), 1'b0, 1'b0, 32'h0, "R10 load view");
    for (int k = 0; k < 20; k++) cycle(1'b0, '0, 1'b1, 1'b0, 32'h0, "R3 R4 keystream");
    // R5: initialization mode with injected words
    cycle(1'b1, rand_words(), 1'b0, 1'b0, 32'h0, "R2 load");
    for (int k = 0; k < 32; k++) cycle(1'b0, '0, 1'b1, 1'b1, $urandom, "R5 init");
    // R9: hold while init and nl_word toggle
    for (int k = 0; k < 6; k++) cycle(1'b0, '0, 1'b0, k[0], $urandom, "R9 hold");
    // R2: load wins over step
    cycle(1'b1, rand_words(), 1'b1, 1'b1, $urandom, "R2 load over step");
    // Mixed random traffic
    for (int k = 0; k < 400; k++) begin
      int sel = $urandom_range(0, 9);
      if (sel == 0)      cycle(1'b1, rand_words(), $urandom_range(0,1) == 1, 1'b0, $urandom, "R2 mix");
      else if (sel < 3)  cycle(1'b0, '0, 1'b0, $urandom_range(0,1) == 1, $urandom, "R9 mix");
      else if (sel < 6)  cycle(1'b0, '0, 1'b1, 1'b1, $urandom, "R5 mix");
      else               cycle(1'b0, '0, 1'b1, 1'b0, $urandom, "R4 mix");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule